// File: doc/BRIEF.md
# Double-Buffered 10-Bit Pulse-Width Modulator

This block generates a single pulse-width modulated output from an 8-bit up-counting time base. The time base is extended by two low-order sub-count bits. This gives 10-bit duty resolution, while the period is still set by an 8-bit limit register. A prescaler in front of the sub-count stretches every count step by 1, 4 or 16 clocks.

The duty value is written as an 8-bit upper part plus a 2-bit lower field held in the control register. Software may write these at any time. The active duty lives in a read-only shadow, and the shadow is reloaded only when the time base wraps. A new duty value therefore never disturbs a period that is already running.

A postscaler counts period wraps and emits a one-cycle event every 1 to 16 periods, without touching the PWM frequency. A single enable bit in the control register starts and stops the whole block. A separate output-enable input gates the pin.

Top module: `pwm10_gen`

## Requirements
- R1: After reset the timer, the active duty, the period event and the pin output are all zero, and the timer stays at zero while the enable bit (control bit 0) is clear.
- R2: With control bits [4:3] as the prescale select (0 gives 1, 1 gives 4, 2 and 3 give 16), the PWM period lasts (period register + 1) × 4 × prescale clock cycles.
- R3: The active duty D is {upper register, control bits [2:1]}. The output goes high in the first cycle of a period and stays high for D × prescale clock cycles.
- R4: When the active duty is zero the output stays low for the whole period.
- R5: When the active duty is at or above (period register + 1) × 4, the output stays high for the whole period.
- R6: The active duty (duty_act_o) changes only in the first cycle of a period. A duty write made mid-period leaves the high time of that period unchanged and takes effect in the next period.
- R7: With control bits [8:5] equal to S, period_evt_o is a one-cycle pulse in the first cycle of every (S + 1)-th period. The PWM period is unchanged by S.
- R8: Writing the control register with the enable bit clear forces pwm_o low from the next cycle and holds the timer at zero from the cycle after.
- R9: pin_en_o follows oe_i, and pwm_o is low whenever oe_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| per_we_i | input | 1 | Period register write strobe |
| per_wdata_i | input | 8 | Period register write data |
| duty_we_i | input | 1 | Duty upper register write strobe |
| duty_wdata_i | input | 8 | Duty upper 8 bits |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 9 | Control: [0] enable, [2:1] duty low bits, [4:3] prescale, [8:5] postscale |
| oe_i | input | 1 | Pin output enable |
| pwm_o | output | 1 | PWM pin value |
| pin_en_o | output | 1 | Pin driver enable |
| period_evt_o | output | 1 | Postscaled period event |
| duty_act_o | output | 10 | Active (shadow) duty, read-only |
| tmr_o | output | 8 | Current 8-bit timer value |

## Verification
The bench builds the block with its default parameters: an 8-bit time base, 2 sub-count bits, a 2-bit prescale select and a 4-bit postscale select. With these widths a full 256-step period fits in about a thousand cycles. Every prescale setting, including the duplicated divide-by-16 code, can be measured end to end. The postscaler's longest ratio is also reachable in a short run.

Zero, saturated and above-period duty values can all be written with these widths. A single-step period (period register 0) is reachable as well, which exercises the wrap on every fourth sub-count.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  localparam int unsigned CNT_W      = 8;
  localparam int unsigned SUB_W      = 2;
  localparam int unsigned PRE_SEL_W  = 2;
  localparam int unsigned PRE_CNT_W  = 4;
  localparam int unsigned POST_SEL_W = 4;
  localparam int unsigned DUTY_W     = CNT_W + SUB_W;
  // control register layout: enable, duty low bits, prescale, postscale
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned LO_LSB     = 1;
  localparam int unsigned PRE_LSB    = LO_LSB + SUB_W;
  localparam int unsigned POST_LSB   = PRE_LSB + PRE_SEL_W;
  localparam int unsigned CTRL_W     = POST_LSB + POST_SEL_W;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned SEL_W = pwm10_pkg::PRE_SEL_W,
  parameter int unsigned CNT_W = pwm10_pkg::PRE_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [SEL_W:0]   shamt;
  logic [CNT_W:0]   one_sh;

  // divide by 4**sel, saturated at 2**CNT_W
  always_comb begin
    shamt = {sel_i, 1'b0};
    if (shamt > (SEL_W+1)'(CNT_W)) shamt = (SEL_W+1)'(CNT_W);
    one_sh = (CNT_W+1)'(1) << shamt;
    lim    = CNT_W'(one_sh - (CNT_W+1)'(1));
  end

  assign tick_o = !clr_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q >= lim)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W = pwm10_pkg::CNT_W,
  parameter int unsigned SUB_W = pwm10_pkg::SUB_W,
  localparam int unsigned FULL_W = CNT_W + SUB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  per_i,
  output logic [CNT_W-1:0]  tmr_o,
  output logic              roll_o,
  output logic [FULL_W-1:0] nxt_cnt_o
);
  logic [CNT_W-1:0] tmr_q;
  logic [SUB_W-1:0] sub_q;
  logic             terminal;

  assign terminal  = (tmr_q == per_i) && (&sub_q);
  assign roll_o    = tick_i && terminal;
  assign nxt_cnt_o = {tmr_q, sub_q} + 1'b1;
  assign tmr_o     = tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      sub_q <= '0;
    end else if (clr_i) begin
      tmr_q <= '0;
      sub_q <= '0;
    end else if (tick_i) begin
      if (terminal) begin
        tmr_q <= '0;
        sub_q <= '0;
      end else begin
        {tmr_q, sub_q} <= nxt_cnt_o;
      end
    end
  end
endmodule

// File: rtl/pwm_duty_out.sv
module pwm_duty_out #(
  parameter int unsigned DUTY_W = pwm10_pkg::DUTY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              roll_i,
  input  logic [DUTY_W-1:0] nxt_cnt_i,
  input  logic [DUTY_W-1:0] duty_new_i,
  output logic [DUTY_W-1:0] duty_act_o,
  output logic              out_o
);
  logic [DUTY_W-1:0] shadow_q;
  logic              out_q;

  assign duty_act_o = shadow_q;
  assign out_o      = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (roll_i) shadow_q <= duty_new_i;
  end

  // set at wrap unless new duty is zero; clear when count reaches duty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              out_q <= 1'b0;
    else if (clr_i)                           out_q <= 1'b0;
    else if (roll_i)                          out_q <= |duty_new_i;
    else if (tick_i && nxt_cnt_i == shadow_q) out_q <= 1'b0;
  end
endmodule

// File: rtl/pwm_postscaler.sv
module pwm_postscaler #(
  parameter int unsigned SEL_W = pwm10_pkg::POST_SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             roll_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             evt_o
);
  logic [SEL_W-1:0] cnt_q;
  logic             evt_q;
  logic             hit;

  assign hit   = cnt_q >= sel_i;
  assign evt_o = evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= roll_i && hit;
      if (roll_i) cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen #(
  parameter int unsigned CNT_W      = pwm10_pkg::CNT_W,
  parameter int unsigned SUB_W      = pwm10_pkg::SUB_W,
  parameter int unsigned PRE_SEL_W  = pwm10_pkg::PRE_SEL_W,
  parameter int unsigned PRE_CNT_W  = pwm10_pkg::PRE_CNT_W,
  parameter int unsigned POST_SEL_W = pwm10_pkg::POST_SEL_W,
  localparam int unsigned DUTY_W    = CNT_W + SUB_W,
  localparam int unsigned LO_LSB    = 1,
  localparam int unsigned PRE_LSB   = LO_LSB + SUB_W,
  localparam int unsigned POST_LSB  = PRE_LSB + PRE_SEL_W,
  localparam int unsigned CTRL_W    = POST_LSB + POST_SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              per_we_i,
  input  logic [CNT_W-1:0]  per_wdata_i,
  input  logic              duty_we_i,
  input  logic [CNT_W-1:0]  duty_wdata_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              oe_i,
  output logic              pwm_o,
  output logic              pin_en_o,
  output logic              period_evt_o,
  output logic [DUTY_W-1:0] duty_act_o,
  output logic [CNT_W-1:0]  tmr_o
);
  logic [CNT_W-1:0]  per_q;
  logic [CNT_W-1:0]  duty_hi_q;
  logic [CTRL_W-1:0] ctrl_q;

  logic                  en;
  logic                  clr;
  logic [SUB_W-1:0]      duty_lo;
  logic [PRE_SEL_W-1:0]  pre_sel;
  logic [POST_SEL_W-1:0] post_sel;
  logic                  tick;
  logic                  roll;
  logic [DUTY_W-1:0]     nxt_cnt;
  logic                  out_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q     <= '0;
      duty_hi_q <= '0;
      ctrl_q    <= '0;
    end else begin
      if (per_we_i)  per_q     <= per_wdata_i;
      if (duty_we_i) duty_hi_q <= duty_wdata_i;
      if (ctrl_we_i) ctrl_q    <= ctrl_wdata_i;
    end
  end

  assign en       = ctrl_q[0];
  assign clr      = !en;
  assign duty_lo  = ctrl_q[PRE_LSB-1:LO_LSB];
  assign pre_sel  = ctrl_q[POST_LSB-1:PRE_LSB];
  assign post_sel = ctrl_q[CTRL_W-1:POST_LSB];

  pwm_prescaler #(.SEL_W(PRE_SEL_W), .CNT_W(PRE_CNT_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .sel_i  (pre_sel),
    .tick_o (tick)
  );

  pwm_timebase #(.CNT_W(CNT_W), .SUB_W(SUB_W)) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .tick_i    (tick),
    .per_i     (per_q),
    .tmr_o     (tmr_o),
    .roll_o    (roll),
    .nxt_cnt_o (nxt_cnt)
  );

  pwm_duty_out #(.DUTY_W(DUTY_W)) u_duty (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .tick_i     (tick),
    .roll_i     (roll),
    .nxt_cnt_i  (nxt_cnt),
    .duty_new_i ({duty_hi_q, duty_lo}),
    .duty_act_o (duty_act_o),
    .out_o      (out_raw)
  );

  pwm_postscaler #(.SEL_W(POST_SEL_W)) u_post (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .roll_i (roll),
    .sel_i  (post_sel),
    .evt_o  (period_evt_o)
  );

  // disable forces the pin low without waiting for the stage registers
  assign pwm_o    = oe_i && en && out_raw;
  assign pin_en_o = oe_i;
endmodule

// File: rtl/pwm10_gen_chk.sv
module pwm10_gen_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DUTY_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              oe_i,
  input logic              pwm_o,
  input logic              pin_en_o,
  input logic              period_evt_o,
  input logic [DUTY_W-1:0] duty_act_o,
  input logic [CNT_W-1:0]  tmr_o
);
  // R1
  reset_tmr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (tmr_o == '0));
  // R2
  tmr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_o != $past(tmr_o)) |-> (tmr_o == '0 || tmr_o == CNT_W'($past(tmr_o) + 1'b1)));
  // R4
  zero_duty_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_act_o == '0) |-> !pwm_o);
  // R6
  shadow_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(duty_act_o) |-> (tmr_o == '0));
  // R7
  evt_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_evt_o |-> (tmr_o == '0));
  // R7
  evt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_evt_o |=> !period_evt_o);
  // R9
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (!pwm_o && !pin_en_o));
  // R9
  pin_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> pin_en_o);
endmodule

bind pwm10_gen pwm10_gen_chk #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en),
  .oe_i         (oe_i),
  .pwm_o        (pwm_o),
  .pin_en_o     (pin_en_o),
  .period_evt_o (period_evt_o),
  .duty_act_o   (duty_act_o),
  .tmr_o        (tmr_o)
);

// File: tb/tb_pwm10_gen.sv
`timescale 1ns/1ps
module tb_pwm10_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       per_we_i = 1'b0;
  logic [7:0] per_wdata_i = '0;
  logic       duty_we_i = 1'b0;
  logic [7:0] duty_wdata_i = '0;
  logic       ctrl_we_i = 1'b0;
  logic [8:0] ctrl_wdata_i = '0;
  logic       oe_i = 1'b1;
  logic       pwm_o, pin_en_o, period_evt_o;
  logic [9:0] duty_act_o;
  logic [7:0] tmr_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  pwm10_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .per_we_i(per_we_i), .per_wdata_i(per_wdata_i),
    .duty_we_i(duty_we_i), .duty_wdata_i(duty_wdata_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .oe_i(oe_i), .pwm_o(pwm_o), .pin_en_o(pin_en_o),
    .period_evt_o(period_evt_o), .duty_act_o(duty_act_o), .tmr_o(tmr_o)
  );

  // fields: period[19:12], duty[11:2], prescale select[1:0]
  localparam int NV = 9;
  localparam logic [19:0] VEC [NV] = '{
    {8'd3,   10'd5,    2'd0},  // R3
    {8'd3,   10'd0,    2'd0},  // R4
    {8'd3,   10'd16,   2'd0},  // R5 exactly full
    {8'd3,   10'd1023, 2'd0},  // R5 above full
    {8'd7,   10'd13,   2'd1},  // R2 div 4
    {8'd2,   10'd7,    2'd2},  // R2 div 16
    {8'd0,   10'd2,    2'd0},  // single-step period
    {8'd9,   10'd39,   2'd3},  // R2 code 3 = div 16
    {8'd255, 10'd1000, 2'd0}   // full 8-bit period
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic cfg(input int per, input int duty, input int pre, input int post);
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_wdata_i = '0;
    @(negedge clk_i);
    per_we_i = 1'b1;  per_wdata_i = 8'(per);
    duty_we_i = 1'b1; duty_wdata_i = 8'(duty >> 2);
    ctrl_wdata_i = {4'(post), 2'(pre), 2'(duty), 1'b1};
    @(negedge clk_i);
    per_we_i = 1'b0; duty_we_i = 1'b0; ctrl_we_i = 1'b0;
  endtask

  task automatic wait_evt();
    do @(negedge clk_i); while (!period_evt_o);
  endtask

  // called at a negedge where period_evt_o is high; runs to the next event
  task automatic measure(output int hi, output int cyc);
    hi = 0; cyc = 0;
    do begin
      hi += int'(pwm_o); cyc++;
      @(negedge clk_i);
    end while (!period_evt_o);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int hi, cyc, div, full, exp_hi, rises;
    logic prev;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 pwm", int'(pwm_o), 0);
    chk("R1 duty_act", int'(duty_act_o), 0);
    chk("R1 tmr", int'(tmr_o), 0);
    chk("R1 evt", int'(period_evt_o), 0);
    repeat (20) @(negedge clk_i);
    chk("R1 tmr idle", int'(tmr_o), 0);

    for (int i = 0; i < NV; i++) begin
      div  = (VEC[i][1:0] == 2'd0) ? 1 : (VEC[i][1:0] == 2'd1) ? 4 : 16;
      full = (int'(VEC[i][19:12]) + 1) * 4;
      exp_hi = (int'(VEC[i][11:2]) < full) ? int'(VEC[i][11:2]) : full;
      cfg(int'(VEC[i][19:12]), int'(VEC[i][11:2]), int'(VEC[i][1:0]), 0);
      wait_evt();
      chk($sformatf("R6 vec%0d duty_act", i), int'(duty_act_o), int'(VEC[i][11:2]));
      measure(hi, cyc);
      chk($sformatf("R2 vec%0d period", i), cyc, full * div);
      chk($sformatf("R3 R4 R5 vec%0d high", i), hi, exp_hi * div);
    end

    // R6 mid-period duty write
    cfg(7, 8, 0, 0);
    wait_evt();
    hi = 0; cyc = 0;
    do begin
      hi += int'(pwm_o); cyc++;
      if (cyc == 6) begin duty_we_i = 1'b0; ctrl_we_i = 1'b0; end
      if (cyc == 5) begin
        duty_we_i = 1'b1; duty_wdata_i = 8'd5;
        ctrl_we_i = 1'b1; ctrl_wdata_i = 9'b0_0000_0001;
      end
      if (cyc == 10) chk("R6 shadow held", int'(duty_act_o), 8);
      @(negedge clk_i);
    end while (!period_evt_o);
    chk("R6 old period high", hi, 8);
    chk("R6 old period len", cyc, 32);
    chk("R6 new shadow", int'(duty_act_o), 20);
    measure(hi, cyc);
    chk("R6 new period high", hi, 20);

    // R7 postscale by 4, PWM period unchanged
    cfg(1, 3, 0, 3);
    wait_evt();
    cyc = 0; rises = 0; prev = 1'b0; hi = 0;
    do begin
      if (pwm_o && !prev) rises++;
      prev = pwm_o; hi += int'(pwm_o); cyc++;
      @(negedge clk_i);
    end while (!period_evt_o);
    chk("R7 event spacing", cyc, 32);
    chk("R7 pwm periods", rises, 4);
    chk("R7 high total", hi, 12);
    @(negedge clk_i);
    chk("R7 pulse width", int'(period_evt_o), 0);

    // R9 output enable gating
    cfg(3, 1023, 0, 0);
    wait_evt();
    @(negedge clk_i);
    chk("R9 pwm high", int'(pwm_o), 1);
    oe_i = 1'b0; #1;
    chk("R9 pwm gated", int'(pwm_o), 0);
    chk("R9 pin_en off", int'(pin_en_o), 0);
    oe_i = 1'b1; #1;
    chk("R9 pwm restored", int'(pwm_o), 1);
    chk("R9 pin_en on", int'(pin_en_o), 1);

    // R8 disable via control clear
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_wdata_i = '0;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
    chk("R8 pwm low", int'(pwm_o), 0);
    @(negedge clk_i);
    chk("R8 tmr zero", int'(tmr_o), 0);
    repeat (10) @(negedge clk_i);
    chk("R8 tmr held", int'(tmr_o), 0);
    chk("R8 pwm held low", int'(pwm_o), 0);

    summary();
  end
endmodule